// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller for a pin count that is a multiple of 32. Its registers are grouped by feature: each feature occupies a bank of one 32-bit word per 32 pins, and the banks follow one another in a fixed order. Software reads the synchronised pin levels and programs each pin's direction. It drives outputs only through write-one set and write-one clear words. It also stores a 2-bit function-select code per pin for an external multiplexer.

Every input passes through a two-flop synchroniser. A per-pin detector compares the synchronised level with its value one cycle earlier. Rising and falling edges are enabled separately per pin. An enabled edge latches a status bit, which software clears by writing one to it. The OR of all status bits forms a single interrupt line for the host.

The bus side is a small access machine with two states. `ST_IDLE` waits for a request. A read request (`bus_en` high, `bus_we` low) moves it to `ST_RESP` and captures the read word. `ST_RESP` presents `bus_rvalid` for that one cycle. It returns to `ST_IDLE`, or stays in `ST_RESP` when a new read arrives at once. Writes take effect at the clock edge where they are presented and never leave `ST_IDLE`.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Word index i = bus_addr/4 selects bank i / NREG and word i mod NREG, where NREG = NPINS/32. Banks 0..6 are, in order: level, direction, set, clear, rising enable, falling enable, status. Pin p maps to bit p mod 32 of word p/32.
- R2: The level bank is read-only. It returns each pin_in value after a two-flop synchroniser, whatever the pin's direction. Writes to it have no effect.
- R3: The direction bank is read/write. A bit of 1 drives the matching pin_oe bit high (output) and 0 makes the pin an input.
- R4: Writing 1 to a bit of the set bank drives that pin_out bit high. Bits written 0 leave pin_out unchanged. The set bank reads as zero.
- R5: Writing 1 to a bit of the clear bank drives that pin_out bit low. Bits written 0 leave pin_out unchanged. The clear bank reads as zero.
- R6: The function-select bank starts at word index 7*NREG and spans 2*NREG words. Pin p's 2-bit code lives in word p/16 at bits (p mod 16)*2+1 : (p mod 16)*2. It is read/write and appears on af_sel[2p+1:2p].
- R7: Rising and falling enables are independent per pin. A rising edge sets the status bit only if the rising enable is set, and a falling edge only if the falling enable is set. Setting both captures either edge.
- R8: A change on pin_in sets the status bit at the third rising clock edge after it. Writing 1 to a status bit clears it, and writing 0 leaves it.
- R9: If an enabled edge is detected in the same cycle that software clears its status bit, the bit stays set.
- R10: irq is high exactly when at least one status bit is set.
- R11: Word indices at or above 9*NREG read as zero, and writes to them change nothing.
- R12: After reset, all banks read zero and pin_out, pin_oe, af_sel and irq are zero.
- R13: A read request is answered on the next cycle with bus_rvalid high for exactly one cycle and the word on bus_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (7 bits for 64 pins) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Output latch |
| pin_oe | output | NPINS | Output enable (direction) |
| af_sel | output | 2*NPINS | Function-select codes, 2 bits per pin |
| irq | output | 1 | OR of all edge-status bits |

## Verification
Assertions in the RTL check several rules on every clock cycle:
- a status bit only appears where an enable was set;
- a detected edge is never lost to a simultaneous clear;
- pin_out holds unless a set or clear word is written;
- unmapped writes leave every register alone;
- bus_rvalid follows each read request by exactly one cycle.

Only the bench scenarios show the rest. These are the exact address map, the bit packing of the function codes, the three-cycle latency from pin to status, and the difference between rising-only, falling-only and both-edge capture. They also cover zero reads from the write-only and unmapped words.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
    localparam int WORD_W   = 32;
    localparam int MAIN_BKS = 7;

    typedef enum logic [2:0] {
        BK_LEVEL = 3'd0,
        BK_DIR   = 3'd1,
        BK_SET   = 3'd2,
        BK_CLR   = 3'd3,
        BK_RISE  = 3'd4,
        BK_FALL  = 3'd5,
        BK_STAT  = 3'd6,
        BK_ALT   = 3'd7
    } bank_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    for (genvar i = 0; i < W; i++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                stab_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= d[i];
                stab_q[i] <= meta_q[i];
            end
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/gpio_edge_capture.sv
module gpio_edge_capture #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr,
    output logic [W-1:0] status,
    output logic         irq
);
    logic [W-1:0] prev_q;
    logic [W-1:0] stat_q;
    logic [W-1:0] hit;

    assign hit = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= lvl;
            stat_q <= (stat_q & ~clr) | hit;
        end
    end

    assign status = stat_q;
    assign irq    = |stat_q;

    // R7: a newly set status bit needs an enable from the previous cycle
    a_r7_status_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~$past(stat_q) & ~$past(rise_en | fall_en)) == '0);

    // R9: an edge seen in a cycle is latched even if cleared in that cycle
    a_r9_clear_keeps_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & $past(hit)) == $past(hit));

    // R12: status is empty on the first cycle out of reset
    a_r12_status_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (stat_q == '0));
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    bus_state_e state_q, state_d;
    logic [WORD_W-1:0] rdata_q;
    logic rd_req;

    assign rd_req = en && !we;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_req) state_d = ST_RESP;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) rdata_q <= rd_word;
        end
    end

    always_comb begin
        rvalid = (state_q == ST_RESP);
        rdata  = rvalid ? rdata_q : '0;
    end

    // R13: exactly one response cycle per read request
    a_r13_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid == $past(rd_req));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NPINS  = 64,
    parameter int ADDR_W = $clog2((NPINS / 32) * 9 * 4)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    input  logic [NPINS-1:0]     pin_in,
    output logic [NPINS-1:0]     pin_out,
    output logic [NPINS-1:0]     pin_oe,
    output logic [2*NPINS-1:0]   af_sel,
    output logic                 irq
);
    localparam int NREG     = NPINS / WORD_W;
    localparam int MAIN_END = MAIN_BKS * NREG;
    localparam int ALT_END  = MAIN_END + 2 * NREG;

    logic [NPINS-1:0]   level_s;
    logic [NPINS-1:0]   dir_q, out_q, ren_q, fen_q;
    logic [2*NPINS-1:0] af_q;
    logic [NPINS-1:0]   status;
    logic [NPINS-1:0]   wmask, clr_stat;
    logic [2*NPINS-1:0] amask;

    logic [ADDR_W-3:0] widx;
    int unsigned widx_i, bank_i, word_i, alt_i;
    logic   main_hit, alt_hit, wr;
    bank_e  bank_sel;
    logic [WORD_W-1:0] rd_word;
    logic   unused_lo;

    assign unused_lo = ^bus_addr[1:0];
    assign widx      = bus_addr[ADDR_W-1:2];
    assign wr        = bus_en && bus_we;

    // address decode
    always_comb begin
        widx_i   = 32'(widx);
        main_hit = widx_i < MAIN_END;
        alt_hit  = !main_hit && (widx_i < ALT_END);
        bank_i   = widx_i / NREG;
        word_i   = widx_i % NREG;
        alt_i    = alt_hit ? (widx_i - MAIN_END) : 0;
        bank_sel = main_hit ? bank_e'(bank_i[2:0]) : BK_ALT;
    end

    // write data placed at the addressed word
    always_comb begin
        wmask = '0;
        wmask[word_i*WORD_W +: WORD_W] = bus_wdata;
        amask = af_q;
        amask[alt_i*WORD_W +: WORD_W] = bus_wdata;
    end

    assign clr_stat = (wr && main_hit && bank_sel == BK_STAT) ? wmask : '0;

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (level_s)
    );

    gpio_edge_capture #(.W(NPINS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (level_s),
        .rise_en(ren_q),
        .fall_en(fen_q),
        .clr    (clr_stat),
        .status (status),
        .irq    (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
            ren_q <= '0;
            fen_q <= '0;
            af_q  <= '0;
        end else if (wr) begin
            if (main_hit) begin
                unique case (bank_sel)
                    BK_DIR:  dir_q[word_i*WORD_W +: WORD_W] <= bus_wdata;
                    BK_SET:  out_q <= out_q | wmask;
                    BK_CLR:  out_q <= out_q & ~wmask;
                    BK_RISE: ren_q[word_i*WORD_W +: WORD_W] <= bus_wdata;
                    BK_FALL: fen_q[word_i*WORD_W +: WORD_W] <= bus_wdata;
                    default: ;
                endcase
            end else if (alt_hit) begin
                af_q <= amask;
            end
        end
    end

    // read mux
    always_comb begin
        rd_word = '0;
        if (main_hit) begin
            unique case (bank_sel)
                BK_LEVEL: rd_word = level_s[word_i*WORD_W +: WORD_W];
                BK_DIR:   rd_word = dir_q[word_i*WORD_W +: WORD_W];
                BK_RISE:  rd_word = ren_q[word_i*WORD_W +: WORD_W];
                BK_FALL:  rd_word = fen_q[word_i*WORD_W +: WORD_W];
                BK_STAT:  rd_word = status[word_i*WORD_W +: WORD_W];
                default:  rd_word = '0;
            endcase
        end else if (alt_hit) begin
            rd_word = af_q[alt_i*WORD_W +: WORD_W];
        end
    end

    gpio_bus_fsm u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (bus_en),
        .we     (bus_we),
        .rd_word(rd_word),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign af_sel  = af_q;

    // R4, R5: the output latch moves only on a set or clear write
    a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr && main_hit && (bank_sel == BK_SET || bank_sel == BK_CLR))
        |-> $stable(out_q));

    // R11: writes outside the map touch no register
    a_r11_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr && !main_hit && !alt_hit)
        |-> ($stable(dir_q) && $stable(out_q) && $stable(ren_q)
             && $stable(fen_q) && $stable(af_q)));
endmodule

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/100ps
module gpio_bank_ctrl_bench;
    localparam int NPINS  = 64;
    localparam int ADDR_W = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_en = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NPINS-1:0]  pin_in = '0;
    logic [NPINS-1:0]  pin_out, pin_oe;
    logic [2*NPINS-1:0] af_sel;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    gpio_bank_ctrl #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_gpio_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .af_sel(af_sel), .irq(irq)
    );

    function automatic logic [ADDR_W-1:0] ra(int bank, int word);
        return ADDR_W'((bank * 2 + word) * 4);
    endfunction

    task automatic check_eq(logic [63:0] got, logic [63:0] exp, string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic bus_write(logic [ADDR_W-1:0] a, logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
        exp_t e;
        e.exp = exp; e.tag = tag;
        sb_q.push_back(e);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        @(negedge clk);
    endtask

    // monitor: compares each response with the oldest expectation (R13)
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R13: response with no request, got %h expected none", bus_rdata);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check_eq({32'h0, bus_rdata}, {32'h0, e.exp}, e.tag);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        check_eq(pin_out, 64'h0, "R12 pin_out");
        check_eq(pin_oe, 64'h0, "R12 pin_oe");
        check_eq({63'h0, irq}, 64'h0, "R12 irq");
        check_eq(af_sel[63:0], 64'h0, "R12 af_sel");
        bus_read(ra(1, 0), 32'h0, "R12 dir");
        bus_read(ra(4, 1), 32'h0, "R12 rise");
        bus_read(ra(5, 0), 32'h0, "R12 fall");
        bus_read(ra(6, 1), 32'h0, "R12 stat");

        // R3 / R1 direction words
        bus_write(ra(1, 0), 32'hA5A5_0F0F);
        bus_write(ra(1, 1), 32'h1234_5678);
        check_eq(pin_oe, 64'h1234_5678_A5A5_0F0F, "R3 pin_oe");
        bus_read(ra(1, 0), 32'hA5A5_0F0F, "R3 dir word0");
        bus_read(ra(1, 1), 32'h1234_5678, "R1 dir word1");

        // R4 / R5 set and clear
        bus_write(ra(2, 0), 32'h0000_0011);
        check_eq(pin_out, 64'h11, "R4 set");
        bus_write(ra(2, 0), 32'h0000_0100);
        check_eq(pin_out, 64'h111, "R4 zero bits keep");
        bus_write(ra(2, 1), 32'h8000_0000);
        check_eq(pin_out, 64'h8000_0000_0000_0111, "R1 set pin 63");
        bus_write(ra(3, 0), 32'h0000_0001);
        check_eq(pin_out, 64'h8000_0000_0000_0110, "R5 clear");
        bus_read(ra(2, 0), 32'h0, "R4 set reads zero");
        bus_read(ra(3, 1), 32'h0, "R5 clear reads zero");

        // R2 level read, independent of direction, writes ignored
        pin_in = 64'hDEAD_BEEF_0123_4567;
        repeat (3) @(negedge clk);
        bus_read(ra(0, 0), 32'h0123_4567, "R2 level word0");
        bus_read(ra(0, 1), 32'hDEAD_BEEF, "R2 level word1");
        bus_write(ra(0, 0), 32'hFFFF_FFFF);
        bus_read(ra(0, 0), 32'h0123_4567, "R2 level write ignored");
        pin_in = '0;
        repeat (3) @(negedge clk);

        // R6 function-select packing
        bus_write(7'((14 + 0) * 4), 32'h0000_0800);
        check_eq({62'h0, af_sel[11:10]}, 64'h2, "R6 pin5 code");
        bus_write(7'((14 + 3) * 4), 32'hC000_0001);
        check_eq({62'h0, af_sel[97:96]}, 64'h1, "R6 pin48 code");
        check_eq({62'h0, af_sel[127:126]}, 64'h3, "R6 pin63 code");
        bus_read(7'((14 + 3) * 4), 32'hC000_0001, "R6 word3 read");

        // R7 / R8 enables and latency
        bus_write(ra(4, 0), 32'h0000_0088);
        bus_write(ra(5, 0), 32'h0000_0080);
        bus_write(ra(5, 1), 32'h0000_0100);
        pin_in[3] = 1'b1;
        repeat (2) @(negedge clk);
        check_eq({63'h0, irq}, 64'h0, "R8 not yet latched");
        @(negedge clk);
        check_eq({63'h0, irq}, 64'h1, "R8 latched on third edge");
        bus_read(ra(6, 0), 32'h0000_0008, "R8 rise pin3");
        bus_write(ra(6, 0), 32'h0000_0000);
        bus_read(ra(6, 0), 32'h0000_0008, "R8 write zero keeps");
        bus_write(ra(6, 0), 32'h0000_0008);
        check_eq({63'h0, irq}, 64'h0, "R10 irq drops");
        bus_read(ra(6, 0), 32'h0, "R8 cleared");
        pin_in[3] = 1'b0;
        repeat (4) @(negedge clk);
        bus_read(ra(6, 0), 32'h0, "R7 falling ignored on rise-only pin");
        pin_in[7] = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(ra(6, 0), 32'h0000_0080, "R7 both rise");
        bus_write(ra(6, 0), 32'h0000_0080);
        pin_in[7] = 1'b0;
        repeat (4) @(negedge clk);
        bus_read(ra(6, 0), 32'h0000_0080, "R7 both fall");
        bus_write(ra(6, 0), 32'h0000_0080);
        pin_in[40] = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(ra(6, 1), 32'h0, "R7 rise ignored on fall-only pin");
        pin_in[40] = 1'b0;
        repeat (4) @(negedge clk);
        bus_read(ra(6, 1), 32'h0000_0100, "R7 fall pin40");
        check_eq({63'h0, irq}, 64'h1, "R10 irq high word1");
        bus_write(ra(6, 1), 32'h0000_0100);
        check_eq({63'h0, irq}, 64'h0, "R10 irq low");

        // R9 clear coinciding with a new edge
        bus_write(ra(4, 0), 32'h0000_0001);
        bus_write(ra(5, 0), 32'h0000_0001);
        pin_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(ra(6, 0), 32'h0000_0001, "R9 first edge");
        pin_in[0] = 1'b0;
        repeat (2) @(negedge clk);
        bus_write(ra(6, 0), 32'h0000_0001);
        bus_read(ra(6, 0), 32'h0000_0001, "R9 edge kept over clear");
        bus_write(ra(6, 0), 32'h0000_0001);
        bus_read(ra(6, 0), 32'h0, "R9 later clear");

        // R11 unmapped space
        bus_write(7'(18 * 4), 32'hFFFF_FFFF);
        bus_write(7'h7C, 32'hFFFF_FFFF);
        bus_read(7'(18 * 4), 32'h0, "R11 unmapped read");
        bus_read(7'h7C, 32'h0, "R11 top read");
        bus_read(ra(1, 0), 32'hA5A5_0F0F, "R11 dir untouched");
        check_eq(pin_out, 64'h8000_0000_0000_0110, "R11 out untouched");

        repeat (3) @(negedge clk);
        check_eq(64'(sb_q.size()), 64'h0, "R13 all reads answered");
        finish_run();
    end
endmodule